// File: doc/BRIEF.md
# Gaussian Noise Combiner and Channel Adder

This block sits behind four parallel approximate-Gaussian generators. Every cycle it adds their four signed samples, so the central limit theorem flattens the ripple each generator leaves in its distribution. The sum is then cleaned up in two ways. First, a constant offset is added back, because the generators negate by inverting bits, which leaves each sample with a small negative mean. Second, the sum is brought back to unit spread by moving the binary point one place instead of dividing.

The corrected noise is multiplied by a programmable unsigned amplitude. The product is rounded onto the signal grid and added to a transmitted symbol. The result is clamped to the signal range to give the channel output.

A self-check mode keeps a running count, sum and sum of squares of the noise samples. A test environment can use these to confirm that the mean is near zero and the variance near one.

Top module: `gauss_sum_chan`

## Requirements
- R1: After reset every output is zero, both valid outputs are low, and the amplitude register holds unity (1 << GAIN_FRAC).
- R2: `noise_vld` is high in the cycle after an edge where all four bits of `smp_vld` were high, and low after any other edge.
- R3: On such an edge `noise_out` takes the value s0+s1+s2+s3+2 in input LSB units. The constant 2 equals four times half an input LSB. The result is read with FRAC+1 fractional bits, which halves its value.
- R4: When `gain_load` is high at an edge, `gain_in` is stored. The stored value applies to channel outputs from the following edge onward, and the old value applies at the loading edge.
- R5: When all four samples and `sig_vld` are valid at an edge, `chan_out` becomes sig + floor((noise*gain + 2^(SH-1)) / 2^SH), with SH = FRAC+1+GAIN_FRAC-SIG_FRAC. This is the product rounded half upward onto the signal grid.
- R6: A channel result above 2^(SIG_W-1)-1 or below -2^(SIG_W-1) is clamped to that limit.
- R7: `chan_vld` is high in the cycle after an edge where all four samples and `sig_vld` were valid, and low otherwise.
- R8: While `acc_en` is high, each edge with all samples valid adds 1 to `acc_cnt`, the noise value to `acc_sum`, and its square to `acc_sq`. Any edge with `acc_en` low clears all three to zero.
- R9: `noise_out` holds its value across edges where the samples are not all valid. `chan_out` holds its value across edges where the channel condition of R7 is not met.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 4 | Valid flag of each generator sample |
| smp0 | input | SMP_W | Generator sample 0, signed, FRAC fractional bits |
| smp1 | input | SMP_W | Generator sample 1 |
| smp2 | input | SMP_W | Generator sample 2 |
| smp3 | input | SMP_W | Generator sample 3 |
| gain_in | input | GAIN_W | Unsigned amplitude, GAIN_FRAC fractional bits |
| gain_load | input | 1 | Stores gain_in |
| sig_in | input | SIG_W | Transmitted symbol, signed, SIG_FRAC fractional bits |
| sig_vld | input | 1 | Symbol valid |
| acc_en | input | 1 | Self-check accumulation enable; low clears |
| noise_out | output | SMP_W+2 | Corrected unit-variance noise, FRAC+1 fractional bits |
| noise_vld | output | 1 | noise_out updated |
| chan_out | output | SIG_W | Symbol plus scaled noise, saturated |
| chan_vld | output | 1 | chan_out updated |
| acc_sum | output | ACC_W | Signed running sum of noise |
| acc_sq | output | ACC_W | Running sum of squared noise |
| acc_cnt | output | CNT_W | Number of accumulated samples |

## Verification
A wrong offset or binary-point position shows up at `noise_out` on the very first valid edge. The mistake repeats in the running sum, where it grows by the same amount with every sample. A stale or early amplitude register corrupts only the `chan_out` values next to a `gain_load`. The bench therefore puts load edges between valid samples and compares each channel result in the cycle it appears. Rounding and clamping errors show at the output one cycle after the offending inputs. Extreme samples combined with a full-scale symbol drive both clamp limits.

// File: rtl/gauss_sum_chan.sv
module gauss_sum_chan #(
  parameter int SMP_W     = 10,
  parameter int FRAC      = 6,
  parameter int GAIN_W    = 8,
  parameter int GAIN_FRAC = 6,
  parameter int SIG_W     = 12,
  parameter int SIG_FRAC  = 7,
  parameter int ACC_W     = 40,
  parameter int CNT_W     = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [3:0]               smp_vld,
  input  logic signed [SMP_W-1:0]  smp0,
  input  logic signed [SMP_W-1:0]  smp1,
  input  logic signed [SMP_W-1:0]  smp2,
  input  logic signed [SMP_W-1:0]  smp3,
  input  logic [GAIN_W-1:0]        gain_in,
  input  logic                     gain_load,
  input  logic signed [SIG_W-1:0]  sig_in,
  input  logic                     sig_vld,
  input  logic                     acc_en,
  output logic signed [SMP_W+1:0]  noise_out,
  output logic                     noise_vld,
  output logic signed [SIG_W-1:0]  chan_out,
  output logic                     chan_vld,
  output logic signed [ACC_W-1:0]  acc_sum,
  output logic [ACC_W-1:0]         acc_sq,
  output logic [CNT_W-1:0]         acc_cnt
);
  localparam int NZ_W = SMP_W + 2;
  localparam int PW   = NZ_W + GAIN_W + 2;
  localparam int SH   = FRAC + 1 + GAIN_FRAC - SIG_FRAC;
  localparam logic signed [NZ_W-1:0] BIAS = NZ_W'(2);
  localparam logic signed [PW-1:0]   HALF = PW'(1 << (SH - 1));
  localparam logic signed [PW-1:0]   SMAX = PW'((1 << (SIG_W - 1)) - 1);
  localparam logic signed [PW-1:0]   SMIN = ~SMAX;

  logic [GAIN_W-1:0] gain_q;
  logic all_vld, chan_go;
  logic signed [NZ_W-1:0]   noise_d;
  logic signed [PW-1:0]     prod, rnd, csum;
  logic signed [SIG_W-1:0]  chan_d;
  logic signed [2*NZ_W-1:0] sq;

  assign all_vld = &smp_vld;
  assign chan_go = all_vld & sig_vld;

  assign noise_d = NZ_W'(smp0) + NZ_W'(smp1) + NZ_W'(smp2) + NZ_W'(smp3) + BIAS;

  assign prod = PW'(noise_d) * $signed({{(PW-GAIN_W){1'b0}}, gain_q});
  assign rnd  = (prod + HALF) >>> SH;
  assign csum = PW'(sig_in) + rnd;
  assign chan_d = (csum > SMAX) ? SMAX[SIG_W-1:0] :
                  (csum < SMIN) ? SMIN[SIG_W-1:0] : csum[SIG_W-1:0];
  assign sq = noise_d * noise_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gain_q    <= GAIN_W'(1 << GAIN_FRAC);
      noise_out <= '0;
      noise_vld <= 1'b0;
      chan_out  <= '0;
      chan_vld  <= 1'b0;
      acc_sum   <= '0;
      acc_sq    <= '0;
      acc_cnt   <= '0;
    end else begin
      if (gain_load) gain_q <= gain_in;
      noise_vld <= all_vld;
      chan_vld  <= chan_go;
      if (all_vld) noise_out <= noise_d;
      if (chan_go) chan_out <= chan_d;
      if (!acc_en) begin
        acc_sum <= '0;
        acc_sq  <= '0;
        acc_cnt <= '0;
      end else if (all_vld) begin
        acc_sum <= acc_sum + ACC_W'(noise_d);
        acc_sq  <= acc_sq + ACC_W'($unsigned(sq));
        acc_cnt <= acc_cnt + 1'b1;
      end
    end
  end

  p_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    all_vld |=> noise_vld);
  p_chan_sub_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chan_vld |-> noise_vld);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !all_vld |=> $stable(noise_out));
  p_gain_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !gain_load |=> $stable(gain_q));
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |=> (acc_cnt == '0 && acc_sum == '0 && acc_sq == '0));
endmodule

// File: tb/gauss_sum_chan_tb_top.sv
`timescale 1ns/1ps
module gauss_sum_chan_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] smp_vld = '0;
  logic signed [9:0] smp0 = '0, smp1 = '0, smp2 = '0, smp3 = '0;
  logic [7:0] gain_in = '0;
  logic gain_load = 1'b0, sig_vld = 1'b0, acc_en = 1'b0;
  logic signed [11:0] sig_in = '0;
  logic signed [11:0] noise_out, chan_out;
  logic noise_vld, chan_vld;
  logic signed [39:0] acc_sum;
  logic [39:0] acc_sq;
  logic [23:0] acc_cnt;

  int checks = 0, errors = 0;
  bit done = 0;
  longint m_gain = 64, m_noise = 0, m_chan = 0, m_sum = 0, m_sq = 0, m_cnt = 0;
  bit m_nv = 0, m_cv = 0;

  always #2.5 clk = ~clk;

  gauss_sum_chan dut_i (.clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp0(smp0), .smp1(smp1),
    .smp2(smp2), .smp3(smp3), .gain_in(gain_in), .gain_load(gain_load), .sig_in(sig_in),
    .sig_vld(sig_vld), .acc_en(acc_en), .noise_out(noise_out), .noise_vld(noise_vld),
    .chan_out(chan_out), .chan_vld(chan_vld), .acc_sum(acc_sum), .acc_sq(acc_sq), .acc_cnt(acc_cnt));

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint rnd_sh(input longint p);
    longint q = p + 32;
    return (q >= 0) ? q / 64 : -((-q + 63) / 64);
  endfunction

  task automatic cyc(input logic [3:0] v, input int a, input int b, input int c, input int d,
                     input int sg, input bit sv, input int gn, input bit gl, input bit ae,
                     input string tg);
    longint nz, cs;
    bit all;
    @(negedge clk);
    smp_vld = v; smp0 = 10'(a); smp1 = 10'(b); smp2 = 10'(c); smp3 = 10'(d);
    sig_in = 12'(sg); sig_vld = sv; gain_in = 8'(gn); gain_load = gl; acc_en = ae;
    @(posedge clk);
    all = &v;
    nz = a + b + c + d + 2;
    if (all) m_noise = nz;
    m_nv = all;
    m_cv = all && sv;
    if (all && sv) begin
      cs = sg + rnd_sh(nz * m_gain);
      m_chan = (cs > 2047) ? 2047 : (cs < -2048) ? -2048 : cs;
    end
    if (!ae) begin m_sum = 0; m_sq = 0; m_cnt = 0; end
    else if (all) begin m_sum += nz; m_sq += nz * nz; m_cnt++; end
    if (gl) m_gain = gn;
    #1;
    chk({tg, "/R2 noise_vld"}, noise_vld, m_nv);
    chk({tg, "/R3 noise_out"}, noise_out, m_noise);
    chk({tg, "/R7 chan_vld"}, chan_vld, m_cv);
    chk({tg, "/R5 chan_out"}, chan_out, m_chan);
    chk({tg, "/R8 acc_cnt"}, acc_cnt, m_cnt);
    chk({tg, "/R8 acc_sum"}, acc_sum, m_sum);
    chk({tg, "/R8 acc_sq"}, longint'(acc_sq), m_sq);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 noise_vld", noise_vld, 0);
    chk("R1 chan_vld", chan_vld, 0);
    chk("R1 noise_out", noise_out, 0);
    chk("R1 chan_out", chan_out, 0);
    chk("R1 acc_cnt", acc_cnt, 0);
    @(negedge clk); rst_n = 1'b1;
    // R1: unity gain after reset, noise 8+2=10 -> product 640 -> +10
    cyc(4'hF, 2, 2, 2, 2, 100, 1, 0, 0, 0, "R1");
    cyc(4'hF, 0, 0, 0, 0, 0, 1, 0, 0, 0, "R3");
    cyc(4'hF, -3, -4, 5, 1, -7, 1, 0, 0, 0, "R3");
    cyc(4'hF, 511, 511, 511, 511, 0, 1, 0, 0, 0, "R3");
    cyc(4'hF, -512, -512, -512, -512, 0, 1, 0, 0, 0, "R3");
    // R9: partial valids hold outputs
    cyc(4'b0111, 100, 100, 100, 100, 5, 1, 0, 0, 0, "R9");
    cyc(4'b1000, 1, 1, 1, 1, 5, 1, 0, 0, 0, "R9");
    // R7: symbol invalid, noise updates only
    cyc(4'hF, 10, 20, 30, 40, 9, 0, 0, 0, 0, "R7");
    // R4: load at this edge, old gain applies here, new gain afterwards
    cyc(4'hF, 50, -20, 7, 3, 11, 1, 200, 1, 0, "R4");
    cyc(4'hF, 50, -20, 7, 3, 11, 1, 0, 0, 0, "R4");
    cyc(4'hF, -50, 20, -7, -3, 11, 1, 3, 1, 0, "R4");
    cyc(4'hF, -50, 20, -7, -3, 11, 1, 0, 0, 0, "R4");
    cyc(4'hF, 1, 0, 0, 0, 0, 1, 0, 0, 0, "R5");
    // R6: clamp both ways
    cyc(4'hF, 0, 0, 0, 0, 0, 1, 255, 1, 0, "R6");
    cyc(4'hF, 511, 511, 511, 511, 2047, 1, 0, 0, 0, "R6");
    chk("R6 high clamp", chan_out, 2047);
    cyc(4'hF, -512, -512, -512, -512, -2048, 1, 0, 0, 0, "R6");
    chk("R6 low clamp", chan_out, -2048);
    // R8: accumulation with symmetric samples, then clear
    cyc(4'hF, 0, 0, 0, 0, 0, 1, 64, 1, 1, "R8");
    cyc(4'hF, 30, 30, -30, -30, 0, 1, 0, 0, 1, "R8");
    cyc(4'hF, -33, 1, -1, 0, 0, 1, 0, 0, 1, "R8");
    cyc(4'b0011, 9, 9, 9, 9, 0, 1, 0, 0, 1, "R8");
    cyc(4'hF, 64, -64, 64, -64, 0, 1, 0, 0, 1, "R8");
    chk("R8 count", acc_cnt, 4);
    cyc(4'hF, 5, 5, 5, 5, 0, 1, 0, 0, 0, "R8");
    chk("R8 cleared", acc_cnt, 0);
    for (int i = 0; i < 3000; i++) begin
      cyc(($urandom_range(0, 3) != 0) ? 4'hF : 4'($urandom_range(0, 15)),
          int'($urandom_range(0, 1023)) - 512, int'($urandom_range(0, 1023)) - 512,
          int'($urandom_range(0, 1023)) - 512, int'($urandom_range(0, 1023)) - 512,
          int'($urandom_range(0, 4095)) - 2048, 1'($urandom_range(0, 1)),
          int'($urandom_range(0, 255)), ($urandom_range(0, 15) == 0), (i % 500) != 0, "RND");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule